// File: doc/BRIEF.md
# Eight-bit minifloat multiplier

This block multiplies two 8-bit floating-point operands and returns a correctly rounded 8-bit product. The format has one sign bit, a four-bit biased exponent and a three-bit fraction. The exponent bias is seven. Exponent field zero marks denormals and zero, which have an implied leading 0 and effective exponent 1. Exponent field all-ones marks infinity when the fraction is zero and NaN otherwise.

An operand pair is presented with a valid strobe. The product appears exactly two clock cycles later with its own valid strobe. A new pair may be presented on every cycle.

Inside the block, each operand is first classified and its significand, including the hidden bit, and its effective exponent are extracted. The 4x4 significand product and the exponent sum are then registered. In the second stage the product is normalised in either direction. If it falls below the normal range it is shifted right into a denormal, with the shifted-out bits collected as sticky. It is then rounded to nearest with ties to even, and overflow is mapped to infinity. Special operands are resolved by a fixed priority.

Top module: `mf_mul`

## Requirements
- R1: `out_valid` rises exactly two clock cycles after `in_valid` is sampled high, and a stream of one pair per cycle yields one result per cycle in order. After reset, `out_valid` and `out_res` are 0.
- R2: For every result that is not NaN, the sign bit (bit 7) equals the XOR of the two operand sign bits. This also holds for zero and infinity results.
- R3: A finite product that lies in the normal range is rounded to the nearest representable value. When it lies exactly halfway, the candidate whose fraction LSB is 0 is chosen.
- R4: A product whose magnitude is 248 or more after rounding becomes infinity of the result sign (code 0x78 or 0xF8). 240 (0x77) is the largest finite result.
- R5: A product below 2^-6 is delivered as a denormal with gradual underflow, with 1/512 (0x01) as the smallest step. A magnitude exactly 1/1024 rounds to zero, and anything above 1/1024 and below 1/512 rounds to 0x01.
- R6: Denormal operands (exponent field 0, fraction nonzero) take part with significand 0.fff and effective exponent 1, and the product is renormalised.
- R7: Zero (either sign) times a finite value gives zero whose sign is the XOR of the operand signs.
- R8: Infinity times a nonzero finite value or times infinity gives infinity whose sign is the XOR of the operand signs.
- R9: Infinity times zero, or any NaN operand, gives the canonical NaN 0x7C (sign 0, exponent 1111, fraction 100).
- R10: Code layout: bit 7 is the sign, bits 6:3 the exponent biased by 7, and bits 2:0 the fraction. A normal value is (1 + frac/8) * 2^(exp-7) and a denormal value is frac/512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 8 | First operand |
| in_b | input | 8 | Second operand |
| out_valid | output | 1 | Product present this cycle |
| out_res | output | 8 | Rounded product |

## Verification
The embedded properties check, on every cycle, the two-cycle valid latency, the sign rule, the canonical NaN for NaN inputs, the zero result for a zero operand, and that an all-ones exponent never leaves the block with a stray fraction. Only the bench's scenarios can show the numeric behaviour: correct rounding with ties to even, the overflow threshold at 248, and gradual underflow, including the half-step tie into zero. These cases are covered by directed cases and by an exhaustive streamed sweep of all 65,536 operand pairs against a model that picks the nearest code by distance.

// File: rtl/mf_pkg.sv
// Shared definitions for the minifloat multiplier.
// Assumes: operand classes are consumed by the top-level special-case mux.
package mf_pkg;

    // Operand class after decoding.
    typedef enum logic [1:0] {
        CL_ZERO = 2'd0,
        CL_FIN  = 2'd1,
        CL_INF  = 2'd2,
        CL_NAN  = 2'd3
    } opclass_e;

    // Result kind resolved in stage one.
    typedef enum logic [1:0] {
        RK_NUM  = 2'd0,
        RK_ZERO = 2'd1,
        RK_INF  = 2'd2,
        RK_NAN  = 2'd3
    } reskind_e;

endpackage

// File: rtl/mf_unpack.sv
// Splits one operand into sign, class, significand with hidden bit and
// effective exponent (1 for denormals). Purely combinational.
// Assumes: EW >= 2, FW >= 2.
module mf_unpack #(
    parameter int EW = 4,
    parameter int FW = 3,
    localparam int W = 1 + EW + FW
) (
    input  logic [W-1:0]      op,
    output logic              sign,
    output mf_pkg::opclass_e  cls,
    output logic [FW:0]       sig,
    output logic [EW-1:0]     eeff
);
    logic [EW-1:0] efld;
    logic [FW-1:0] ffld;
    logic          e_zero;
    logic          e_ones;

    assign sign   = op[W-1];
    assign efld   = op[W-2:FW];
    assign ffld   = op[FW-1:0];
    assign e_zero = (efld == '0);
    assign e_ones = &efld;

    // Classify the operand and build significand and effective exponent.
    always_comb begin
        sig  = {!e_zero, ffld};
        eeff = e_zero ? EW'(1) : efld;
        if (e_ones)
            cls = (ffld == '0) ? mf_pkg::CL_INF : mf_pkg::CL_NAN;
        else if (e_zero && ffld == '0)
            cls = mf_pkg::CL_ZERO;
        else
            cls = mf_pkg::CL_FIN;
    end
endmodule

// File: rtl/mf_norm_round.sv
// Normalises a nonzero significand product, denormalises it with sticky
// collection when the exponent is below 1, rounds to nearest-even and
// saturates to infinity on overflow. Combinational.
// Assumes: prod != 0; er is the biased sum exp_a + exp_b - bias.
module mf_norm_round #(
    parameter int EW = 4,
    parameter int FW = 3,
    localparam int W   = 1 + EW + FW,
    localparam int PW  = 2 * (FW + 1),
    localparam int XW  = EW + 3
) (
    input  logic              sign,
    input  logic [XW-1:0]     er,
    input  logic [PW-1:0]     prod,
    output logic [W-1:0]      res
);
    localparam int LZW  = $clog2(PW + 1);
    localparam int EMAX = (1 << EW) - 1;

    logic [LZW-1:0]    lz;
    logic [PW-1:0]     norm;
    logic [XW-1:0]     en;
    logic              below;
    logic              ovf;
    logic [XW-1:0]     shs;
    logic [2*PW-1:0]   ext;
    logic [FW-1:0]     frac;
    logic              grd;
    logic              sticky;
    logic [EW-1:0]     efield;
    logic [EW+FW-1:0]  packed_mag;

    // Count leading zeros of the product.
    always_comb begin
        lz = LZW'(PW);
        for (int i = 0; i < PW; i++)
            if (prod[i]) lz = LZW'(PW - 1 - i);
    end

    assign norm  = prod << lz;
    assign en    = er + XW'(1) - XW'(lz);
    assign below = en[XW-1] || (en == '0);
    assign ovf   = !en[XW-1] && (en >= XW'(EMAX));

    // Right-shift amount into the denormal range, saturated past the sticky field.
    always_comb begin
        shs = below ? (XW'(1) - en) : '0;
        if (shs > XW'(PW + 1)) shs = XW'(PW + 1);
    end

    assign ext    = {norm, {PW{1'b0}}} >> shs;
    assign frac   = ext[2*PW-2 -: FW];
    assign grd    = ext[2*PW-2-FW];
    assign sticky = |ext[2*PW-3-FW:0];
    assign efield = ext[2*PW-1] ? en[EW-1:0] : '0;

    // Round to nearest-even; a fraction carry ripples into the exponent.
    always_comb begin
        packed_mag = {efield, frac} + (EW+FW)'(grd & (sticky | frac[0]));
        if (ovf) packed_mag = {{EW{1'b1}}, {FW{1'b0}}};
        res = {sign, packed_mag};
    end
endmodule

// File: rtl/mf_mul.sv
// Two-stage minifloat multiplier. Stage one decodes the operands, resolves
// special cases and registers the significand product and the exponent sum.
// Stage two normalises, rounds and registers the result.
// Assumes: FW >= 2 (canonical NaN uses the top fraction bit).
module mf_mul #(
    parameter int EW = 4,
    parameter int FW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [EW+FW:0]    in_a,
    input  logic [EW+FW:0]    in_b,
    output logic              out_valid,
    output logic [EW+FW:0]    out_res
);
    import mf_pkg::*;

    localparam int W    = 1 + EW + FW;
    localparam int PW   = 2 * (FW + 1);
    localparam int XW   = EW + 3;
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam logic [W-1:0] NAN_CODE = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};
    localparam logic [W-2:0] INF_MAG  = {{EW{1'b1}}, {FW{1'b0}}};

    logic [W-1:0]   ops  [2];
    logic           sgn  [2];
    opclass_e       cls  [2];
    logic [FW:0]    sig  [2];
    logic [EW-1:0]  eeff [2];

    assign ops[0] = in_a;
    assign ops[1] = in_b;

    for (genvar g = 0; g < 2; g++) begin : g_unp
        mf_unpack #(.EW(EW), .FW(FW)) u_unp (
            .op   (ops[g]),
            .sign (sgn[g]),
            .cls  (cls[g]),
            .sig  (sig[g]),
            .eeff (eeff[g])
        );
    end

    reskind_e        kind_d;
    logic            s1_valid;
    reskind_e        s1_kind;
    logic            s1_sign;
    logic [XW-1:0]   s1_er;
    logic [PW-1:0]   s1_prod;
    logic [W-1:0]    nr_res;

    // Resolve the special-case priority: NaN, then infinity, then zero.
    always_comb begin
        if (cls[0] == CL_NAN || cls[1] == CL_NAN ||
            (cls[0] == CL_INF && cls[1] == CL_ZERO) ||
            (cls[0] == CL_ZERO && cls[1] == CL_INF))
            kind_d = RK_NAN;
        else if (cls[0] == CL_INF || cls[1] == CL_INF)
            kind_d = RK_INF;
        else if (cls[0] == CL_ZERO || cls[1] == CL_ZERO)
            kind_d = RK_ZERO;
        else
            kind_d = RK_NUM;
    end

    // Stage one: register the kind, sign, exponent sum and significand product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_kind  <= RK_ZERO;
            s1_sign  <= 1'b0;
            s1_er    <= '0;
            s1_prod  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_kind  <= kind_d;
            s1_sign  <= sgn[0] ^ sgn[1];
            s1_er    <= XW'(eeff[0]) + XW'(eeff[1]) - XW'(BIAS);
            s1_prod  <= PW'(sig[0]) * PW'(sig[1]);
        end
    end

    mf_norm_round #(.EW(EW), .FW(FW)) u_nr (
        .sign (s1_sign),
        .er   (s1_er),
        .prod (s1_prod),
        .res  (nr_res)
    );

    // Stage two: select the final code and register it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= s1_valid;
            case (s1_kind)
                RK_NAN:  out_res <= NAN_CODE;
                RK_INF:  out_res <= {s1_sign, INF_MAG};
                RK_ZERO: out_res <= {s1_sign, {(W-1){1'b0}}};
                default: out_res <= nr_res;
            endcase
        end
    end

    // Port-level observation helpers for the properties below.
    logic a_nan, b_nan, a_zero, b_zero, a_fin_or_zero, b_fin_or_zero;
    assign a_nan  = (&in_a[W-2:FW]) && (|in_a[FW-1:0]);
    assign b_nan  = (&in_b[W-2:FW]) && (|in_b[FW-1:0]);
    assign a_zero = (in_a[W-2:0] == '0);
    assign b_zero = (in_b[W-2:0] == '0);
    assign a_fin_or_zero = !(&in_a[W-2:FW]);
    assign b_fin_or_zero = !(&in_b[W-2:FW]);

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (out_valid == $past(in_valid, 2)));

    p_sign_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && out_valid && out_res != NAN_CODE)
        |-> (out_res[W-1] == $past(in_a[W-1] ^ in_b[W-1], 2)));

    p_inf_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (&out_res[W-2:FW]))
        |-> (out_res[FW-1:0] == '0 || out_res == NAN_CODE));

    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && out_valid &&
         $past((a_zero && b_fin_or_zero) || (b_zero && a_fin_or_zero), 2))
        |-> (out_res[W-2:0] == '0));

    p_nan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && out_valid && $past(a_nan || b_nan, 2))
        |-> (out_res == NAN_CODE));
endmodule

// File: tb/test_mf_mul.sv
// Directed and exhaustive bench for mf_mul. Each scenario task checks its own results.
module test_mf_mul;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_a = '0;
    logic [7:0] in_b = '0;
    logic       out_valid;
    logic [7:0] out_res;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    mf_mul i_mf_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_res   (out_res)
    );

    // Value of a finite code magnitude (sign ignored).
    function automatic real code_val(input logic [6:0] c);
        int e = int'(c[6:3]);
        int f = int'(c[2:0]);
        if (e == 0) return real'(f) / 512.0;
        return real'(8 + f) * (2.0 ** (e - 10));
    endfunction

    // Reference product: nearest code by distance, ties to even LSB.
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic s = a[7] ^ b[7];
        logic a_inf = (a[6:3] == 4'hF) && (a[2:0] == 0);
        logic b_inf = (b[6:3] == 4'hF) && (b[2:0] == 0);
        logic a_nan = (a[6:3] == 4'hF) && (a[2:0] != 0);
        logic b_nan = (b[6:3] == 4'hF) && (b[2:0] != 0);
        logic a_z = (a[6:0] == 0);
        logic b_z = (b[6:0] == 0);
        real v, d, bd;
        logic [6:0] best;
        if (a_nan || b_nan || (a_inf && b_z) || (b_inf && a_z)) return 8'h7C;
        if (a_inf || b_inf) return {s, 7'h78};
        if (a_z || b_z) return {s, 7'h00};
        v = code_val(a[6:0]) * code_val(b[6:0]);
        if (v >= 248.0) return {s, 7'h78};
        best = 7'h00;
        bd = v;
        for (int c = 1; c <= 8'h77; c++) begin
            d = code_val(7'(c)) - v;
            if (d < 0.0) d = -d;
            if (d < bd || (d == bd && c[0] == 1'b0)) begin
                bd = d;
                best = 7'(c);
            end
        end
        return {s, best};
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%02h expected=%02h", req, got, exp);
        end
    endtask

    // One isolated operation: drive, wait the two-cycle latency, check.
    task automatic do_op(input string req, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] exp);
        @(negedge clk);
        in_a = a; in_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({req, " valid"}, {7'b0, out_valid}, 8'h01);
        chk(req, out_res, exp);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        in_valid = 1'b1; in_a = 8'h38; in_b = 8'h38;
        repeat (3) @(negedge clk);
        chk("R1 reset valid", {7'b0, out_valid}, 8'h00);
        chk("R1 reset result", out_res, 8'h00);
        in_valid = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_latency;
        @(negedge clk);
        in_a = 8'h3C; in_b = 8'h3C; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 one cycle after", {7'b0, out_valid}, 8'h00);
        @(negedge clk);
        chk("R1 two cycles after", {7'b0, out_valid}, 8'h01);
        chk("R1 result", out_res, 8'h41);
        @(negedge clk);
        chk("R1 single pulse", {7'b0, out_valid}, 8'h00);
    endtask

    task automatic t_normals;
        do_op("R10 one times one", 8'h38, 8'h38, 8'h38);
        do_op("R3 exact 2.25", 8'h3C, 8'h3C, 8'h41);
        do_op("R3 round down below half", 8'h39, 8'h39, 8'h3A);
        do_op("R2 negative times positive", 8'hBC, 8'h3C, 8'hC1);
        do_op("R2 negative times negative", 8'hBC, 8'hBC, 8'h41);
    endtask

    task automatic t_ties;
        do_op("R3 tie rounds up to even", 8'h39, 8'h3C, 8'h3E);
        do_op("R3 tie stays on even", 8'h3A, 8'h3A, 8'h3C);
    endtask

    task automatic t_overflow;
        do_op("R4 largest finite kept", 8'h77, 8'h38, 8'h77);
        do_op("R4 270 overflows", 8'h77, 8'h39, 8'h78);
        do_op("R4 256 overflows", 8'h58, 8'h58, 8'h78);
        do_op("R4 negative overflow", 8'h77, 8'hB9, 8'hF8);
    endtask

    task automatic t_underflow;
        do_op("R5 half of min normal", 8'h08, 8'h30, 8'h04);
        do_op("R5 smallest step kept", 8'h01, 8'h38, 8'h01);
        do_op("R5 half step tie to zero", 8'h01, 8'h30, 8'h00);
        do_op("R5 above half step", 8'h01, 8'h31, 8'h01);
        do_op("R5 negative smallest", 8'h01, 8'hB4, 8'h81);
        do_op("R5 negative tie to minus zero", 8'h81, 8'h30, 8'h80);
    endtask

    task automatic t_denorm_in;
        do_op("R6 denormal times 16", 8'h04, 8'h58, 8'h20);
        do_op("R6 denormal times 2", 8'h07, 8'h40, 8'h0E);
    endtask

    task automatic t_zero;
        do_op("R7 zero times max", 8'h00, 8'h77, 8'h00);
        do_op("R7 minus zero times one", 8'h80, 8'h38, 8'h80);
        do_op("R7 zero times negative", 8'h00, 8'hB8, 8'h80);
    endtask

    task automatic t_inf;
        do_op("R8 inf times one", 8'h78, 8'h38, 8'h78);
        do_op("R8 inf times minus one", 8'h78, 8'hB8, 8'hF8);
        do_op("R8 minus inf squared", 8'hF8, 8'hF8, 8'h78);
        do_op("R8 inf times denormal", 8'h78, 8'h01, 8'h78);
    endtask

    task automatic t_nan;
        do_op("R9 inf times zero", 8'h78, 8'h00, 8'h7C);
        do_op("R9 minus zero times minus inf", 8'h80, 8'hF8, 8'h7C);
        do_op("R9 NaN operand", 8'h79, 8'h38, 8'h7C);
        do_op("R9 negative NaN times zero", 8'hFF, 8'h00, 8'h7C);
    endtask

    // Every operand pair streamed back to back against the reference (R1..R10).
    task automatic t_sweep;
        logic [7:0] expq [2];
        for (int i = 0; i < 65536 + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R1 streamed valid", {7'b0, out_valid}, 8'h01);
                chk("R3 sweep vs reference", out_res, expq[i % 2]);
            end
            if (i < 65536) begin
                in_a = 8'(i >> 8);
                in_b = 8'(i);
                in_valid = 1'b1;
                expq[i % 2] = ref_mul(8'(i >> 8), 8'(i));
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R1 watchdog expired got=hung expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_latency();
        t_normals();
        t_ties();
        t_overflow();
        t_underflow();
        t_denorm_in();
        t_zero();
        t_inf();
        t_nan();
        t_sweep();
        finish_run();
    end
endmodule